// File: doc/BRIEF.md
# Three-Lane Block FIR with Lags 0, 2 and 3

This block filters a stream of signed samples with the three-tap response y(n) = a·x(n) + b·x(n−2) + c·x(n−3). The lag-one term is absent. The filter is unrolled by three. On each clock where the input is marked valid, it takes three consecutive samples as one block and produces the three matching outputs. The sample rate is therefore three times the clock rate.

Each output lane draws on two sources: the current block, and a small register that holds the last three samples of the previous valid block. The three lanes reach back into that register at different offsets. Lane 0 uses the two oldest held samples. Lane 1 uses the held samples at lags 2 and 3 relative to its own position. Lane 2 uses only the newest held sample.

The datapath is cut into pipeline stages along feed-forward cutsets, so all three lanes share one latency. In the default mode each stage holds one multiply-add, and the latency is 3 clocks. A build-time mode splits every multiply from its add, which gives stages of about half a multiply-add and a latency of 6 clocks. The intended use is a fixed filter: the coefficient inputs are held steady while samples flow.

Top module: `fir3_block_filter`

## Requirements
- R1: Lane 0 (bits [15:0] of the sample buses, the oldest sample of a block) outputs a·x(3k) + b·x(3k−2) + c·x(3k−3) for block k.
- R2: Lane 1 (bits [31:16]) outputs a·x(3k+1) + b·x(3k−1) + c·x(3k−2).
- R3: Lane 2 (bits [47:32], the newest sample) outputs a·x(3k+2) + b·x(3k) + c·x(3k−1).
- R4: No output depends on the sample one position earlier. An impulse in lane 0 gives a zero output in lane 1 of the same block.
- R5: In the default mode, out_valid rises exactly 3 clocks after a block is accepted, and carries that block's outputs. Every accepted block yields exactly one output block.
- R6: The previous-block history loads only on clocks with in_valid high. Samples presented while in_valid is low have no effect on any later output.
- R7: A synchronous active-low reset clears out_valid and the history. The first block after reset sees zero for every earlier sample, and blocks in flight at reset produce no output.
- R8: Samples and coefficients are signed 16-bit. The sum is formed at full precision, arithmetically shifted right by 15, and its low 16 bits are kept. Large sums wrap, and negative results round toward minus infinity.
- R9: With the half-stage mode selected, the outputs are the same as in R1–R3 and out_valid rises exactly 6 clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept the block on in_samples this clock |
| in_samples | input | 48 | Three signed samples; lane i at bits [16i+15:16i], lane 0 oldest |
| coef_a | input | 16 | Signed coefficient for lag 0 |
| coef_b | input | 16 | Signed coefficient for lag 2 |
| coef_c | input | 16 | Signed coefficient for lag 3 |
| out_valid | output | 1 | out_samples holds a valid output block |
| out_samples | output | 48 | Three signed outputs, same lane order as the input |

## Verification
Two things happen on the same clock edge. The history register loads the tail of the block being accepted. The lanes read the old history, which that same block still needs. Feeding blocks back to back, with no idle clock between them, makes these two events fall on every edge. Any ordering fault then shows up as a wrong cross-block term in lanes 0 to 2. The bench compares each lane against a sample-by-sample model. It then repeats the comparison with idle clocks that carry garbage samples, and again across a reset taken while blocks are in flight.

// File: rtl/fir3_pkg.sv
// Package fir3_pkg
// Shared constants and the pipeline-mode type for the three-lane block FIR.
// Assumes a block length of three and a deepest tap lag of three samples.
package fir3_pkg;
    localparam int BLOCK_LEN = 3;
    localparam int MAX_LAG   = 3;
    localparam int TAP_COUNT = 3;

    typedef enum logic {
        STAGE_FULL_MAC = 1'b0,
        STAGE_HALF_MAC = 1'b1
    } stage_mode_e;

    // Clocks spent per tap for a given stage mode.
    function automatic int cycles_per_tap(stage_mode_e mode);
        return (mode == STAGE_HALF_MAC) ? 2 : 1;
    endfunction
endpackage

// File: rtl/fir3_delay.sv
// Module fir3_delay
// Fixed-length register chain that keeps a tap's sample aligned with its
// partial sum. Assumes N >= 1. Clears to zero on synchronous reset.
module fir3_delay #(
    parameter int W = 16,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] chain_q [N];

    // Shift the sample one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < N; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign d_o = chain_q[N-1];
endmodule

// File: rtl/fir3_mac_stage.sv
// Module fir3_mac_stage
// One multiply-add step of a lane: acc_o = (acc_i + smp_i*coef_i) >>> SH,
// cut to OW bits. SPLIT=0 registers the sum once (1 clock). SPLIT=1 puts a
// register between multiply and add (2 clocks). Operands are signed.
module fir3_mac_stage #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int AW    = 34,
    parameter int OW    = 34,
    parameter int SH    = 0,
    parameter bit SPLIT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] acc_i,
    input  logic signed [DW-1:0] smp_i,
    input  logic signed [CW-1:0] coef_i,
    output logic signed [OW-1:0] acc_o
);
    logic signed [AW-1:0] prod;
    logic signed [AW-1:0] full;
    logic signed [OW-1:0] out_q;

    assign prod = AW'(smp_i) * AW'(coef_i);

    if (SPLIT) begin : g_split
        logic signed [AW-1:0] prod_q;
        logic signed [AW-1:0] acc_q;

        // Register product and incoming partial sum separately.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_q <= '0;
                acc_q  <= '0;
            end else begin
                prod_q <= prod;
                acc_q  <= acc_i;
            end
        end

        assign full = acc_q + prod_q;
    end else begin : g_whole
        assign full = acc_i + prod;
    end

    // Register the scaled sum.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= OW'(full >>> SH);
    end

    assign acc_o = out_q;
endmodule

// File: rtl/fir3_lane.sv
// Module fir3_lane
// One output lane: c*x_lag3 first, then + b*x_lag2, then + a*x_now.
// Later taps' samples are delayed to match the partial sum (feed-forward
// cutsets). Latency is 3*STG clocks. Coefficients are assumed static.
module fir3_lane #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int AW   = 34,
    parameter int FRAC = 15,
    parameter int STG  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x_now,
    input  logic signed [DW-1:0] x_lag2,
    input  logic signed [DW-1:0] x_lag3,
    input  logic signed [CW-1:0] coef_a,
    input  logic signed [CW-1:0] coef_b,
    input  logic signed [CW-1:0] coef_c,
    output logic signed [DW-1:0] y_o
);
    localparam bit SPLIT = (STG == 2);

    logic signed [AW-1:0] acc_c;
    logic signed [AW-1:0] acc_b;
    logic signed [DW-1:0] x_lag2_d;
    logic signed [DW-1:0] x_now_d;

    fir3_mac_stage #(.DW(DW), .CW(CW), .AW(AW), .OW(AW), .SH(0), .SPLIT(SPLIT)) u_tap_c (
        .clk(clk), .rst_n(rst_n), .acc_i('0), .smp_i(x_lag3), .coef_i(coef_c), .acc_o(acc_c)
    );

    fir3_delay #(.W(DW), .N(STG)) u_dly_b (
        .clk(clk), .rst_n(rst_n), .d_i(x_lag2), .d_o(x_lag2_d)
    );

    fir3_mac_stage #(.DW(DW), .CW(CW), .AW(AW), .OW(AW), .SH(0), .SPLIT(SPLIT)) u_tap_b (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_c), .smp_i(x_lag2_d), .coef_i(coef_b), .acc_o(acc_b)
    );

    fir3_delay #(.W(DW), .N(2*STG)) u_dly_a (
        .clk(clk), .rst_n(rst_n), .d_i(x_now), .d_o(x_now_d)
    );

    fir3_mac_stage #(.DW(DW), .CW(CW), .AW(AW), .OW(DW), .SH(FRAC), .SPLIT(SPLIT)) u_tap_a (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_b), .smp_i(x_now_d), .coef_i(coef_a), .acc_o(y_o)
    );
endmodule

// File: rtl/fir3_history.sv
// Module fir3_history
// Holds the newest DEPTH samples of the last accepted block. They supply
// the lagged terms for the next block. Loads only when load_i is high;
// clears on synchronous reset. Assumes DEPTH <= LANES.
module fir3_history #(
    parameter int DW    = 16,
    parameter int DEPTH = 3,
    parameter int LANES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [LANES*DW-1:0]    cur_i,
    output logic [DEPTH*DW-1:0]    hist_o
);
    logic [DEPTH*DW-1:0] hist_q;

    // Capture the tail of an accepted block.
    always_ff @(posedge clk) begin
        if (!rst_n)      hist_q <= '0;
        else if (load_i) hist_q <= cur_i[(LANES-DEPTH)*DW +: DEPTH*DW];
    end

    assign hist_o = hist_q;

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(hist_q));

    // R6
    hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> hist_q == $past(cur_i[(LANES-DEPTH)*DW +: DEPTH*DW]));
endmodule

// File: rtl/fir3_block_filter.sv
// Module fir3_block_filter
// Block-of-three FIR, y(n) = a*x(n) + b*x(n-2) + c*x(n-3). Lane i of the
// buses is sample 3k+i. MODE selects one multiply-add per stage or half.
// Assumes coefficients stay steady while blocks are in flight.
module fir3_block_filter
    import fir3_pkg::*;
#(
    parameter int          DW   = 16,
    parameter int          CW   = 16,
    parameter int          FRAC = 15,
    parameter stage_mode_e MODE = STAGE_FULL_MAC
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [BLOCK_LEN*DW-1:0]   in_samples,
    input  logic signed [CW-1:0]      coef_a,
    input  logic signed [CW-1:0]      coef_b,
    input  logic signed [CW-1:0]      coef_c,
    output logic                      out_valid,
    output logic [BLOCK_LEN*DW-1:0]   out_samples
);
    localparam int STG = cycles_per_tap(MODE);
    localparam int LAT = TAP_COUNT * STG;
    localparam int AW  = DW + CW + 2;
    localparam int WIN = MAX_LAG + BLOCK_LEN;

    logic [MAX_LAG*DW-1:0] hist;
    logic [WIN*DW-1:0]     window;
    logic [LAT-1:0]        vld_q;

    fir3_history #(.DW(DW), .DEPTH(MAX_LAG), .LANES(BLOCK_LEN)) u_hist (
        .clk(clk), .rst_n(rst_n), .load_i(in_valid), .cur_i(in_samples), .hist_o(hist)
    );

    // Sample index j of window is x(3k - MAX_LAG + j).
    assign window = {in_samples, hist};

    for (genvar i = 0; i < BLOCK_LEN; i++) begin : g_lane
        logic signed [DW-1:0] y;

        fir3_lane #(.DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC), .STG(STG)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .x_now (window[(i+MAX_LAG)*DW +: DW]),
            .x_lag2(window[(i+MAX_LAG-2)*DW +: DW]),
            .x_lag3(window[(i+MAX_LAG-3)*DW +: DW]),
            .coef_a(coef_a),
            .coef_b(coef_b),
            .coef_c(coef_c),
            .y_o   (y)
        );

        assign out_samples[i*DW +: DW] = y;
    end

    // Carry the input valid down the same number of stages as the data.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LAT-2:0], in_valid};
    end

    assign out_valid = vld_q[LAT-1];

    // R5 R9
    out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, LAT));

    // R7
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/test_fir3_block_filter.sv
module test_fir3_block_filter;
    localparam int FRAC = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               in_valid;
    logic [47:0]        in_samples;
    logic signed [15:0] ca, cb, cc;
    logic               ov0, ov1;
    logic [47:0]        os0, os1;

    fir3_block_filter i_fir3_block_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .coef_a(ca), .coef_b(cb), .coef_c(cc), .out_valid(ov0), .out_samples(os0)
    );

    fir3_block_filter #(.MODE(fir3_pkg::STAGE_HALF_MAC)) i_fir3_block_filter_deep (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .coef_a(ca), .coef_b(cb), .coef_c(cc), .out_valid(ov1), .out_samples(os1)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    string       scen   = "R7";
    longint      h[3];
    logic [47:0] q0[$];
    logic [47:0] q1[$];

    function automatic logic [15:0] trunc16(longint s);
        longint t;
        t = s >>> FRAC;
        return t[15:0];
    endfunction

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Compare one output block against the oldest expected block.
    task automatic cmp(input string dut, input logic [47:0] got, ref logic [47:0] q[$]);
        logic [47:0] exp;
        if (q.size() == 0) begin
            check(1'b0, {"R5 unexpected output ", dut}, 1, 0);
            return;
        end
        exp = q.pop_front();
        for (int i = 0; i < 3; i++) begin
            string tag;
            tag = (i == 0) ? "R1" : (i == 1) ? "R2" : "R3";
            check(got[i*16 +: 16] == exp[i*16 +: 16],
                  $sformatf("%s lane%0d %s scen %s", tag, i, dut, scen),
                  longint'($signed(got[i*16 +: 16])), longint'($signed(exp[i*16 +: 16])));
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n === 1'b1 && ov0 === 1'b1) cmp("base", os0, q0);
        if (rst_n === 1'b1 && ov1 === 1'b1) cmp("deep(R9)", os1, q1);
    end

    // Drive one clock of input; model the block when it is valid.
    task automatic send(input logic [47:0] blk, input bit valid);
        @(negedge clk);
        in_valid   = valid;
        in_samples = blk;
        if (valid) begin
            longint      w[6];
            logic [47:0] e;
            for (int i = 0; i < 3; i++) w[i] = h[i];
            for (int i = 0; i < 3; i++) w[3+i] = longint'($signed(blk[i*16 +: 16]));
            for (int i = 0; i < 3; i++)
                e[i*16 +: 16] = trunc16(longint'(ca) * w[3+i] + longint'(cb) * w[1+i]
                                        + longint'(cc) * w[i]);
            q0.push_back(e);
            q1.push_back(e);
            for (int i = 0; i < 3; i++) h[i] = w[3+i];
        end
    endtask

    task automatic idle_garbage(input int n);
        for (int i = 0; i < n; i++) send({$urandom(), $urandom()}, 1'b0);
    endtask

    task automatic drain(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(q0.size() == 0, {tag, " base blocks outstanding"}, q0.size(), 0);
        check(q1.size() == 0, {tag, " deep blocks outstanding"}, q1.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) h[i] = 0;
        q0.delete();
        q1.delete();
        repeat (3) @(negedge clk);
        check(ov0 == 1'b0, "R7 base out_valid in reset", ov0, 0);
        check(ov1 == 1'b0, "R7 deep out_valid in reset", ov1, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        scen = "R7";
        do_reset();
        idle_garbage(8);
        check(ov0 == 1'b0, "R7 base idle after reset", ov0, 0);
        check(ov1 == 1'b0, "R7 deep idle after reset", ov1, 0);
    endtask

    // Impulse at lane 0: lane 1 of that block must stay zero.
    task automatic t_impulse();
        scen = "R4";
        ca = 16'sd12000; cb = -16'sd7000; cc = 16'sd3000;
        do_reset();
        send({16'd0, 16'd0, 16'd32767}, 1'b1);
        repeat (3) send(48'd0, 1'b1);
        drain("R4");
    endtask

    task automatic t_random();
        scen = "R1 R2 R3 back-to-back";
        ca = 16'sd9000; cb = -16'sd21000; cc = 16'sd15000;
        for (int i = 0; i < 40; i++) send({$urandom(), $urandom()}, 1'b1);
        drain("R3");
    endtask

    task automatic t_gaps();
        scen = "R6";
        ca = -16'sd4000; cb = 16'sd30000; cc = -16'sd11000;
        for (int i = 0; i < 20; i++) begin
            send({$urandom(), $urandom()}, 1'b1);
            idle_garbage(1 + (i % 3));
        end
        drain("R6");
    endtask

    task automatic t_latency();
        int n0, n1;
        scen = "R5";
        n0 = 0;
        n1 = 0;
        send({16'd7, 16'd8, 16'd9}, 1'b1);
        for (int c = 1; c <= 12; c++) begin
            @(posedge clk);
            #2;
            in_valid = 1'b0;
            if (ov0 && n0 == 0) n0 = c;
            if (ov1 && n1 == 0) n1 = c;
        end
        check(n0 == 3, "R5 base latency", n0, 3);
        check(n1 == 6, "R9 deep latency", n1, 6);
        drain("R5");
    endtask

    task automatic t_trunc();
        scen = "R8 wrap";
        ca = -16'sd32768; cb = -16'sd32768; cc = -16'sd32768;
        repeat (3) send({16'h8000, 16'h8000, 16'h8000}, 1'b1);
        drain("R8");
        scen = "R8 floor";
        ca = -16'sd1; cb = 16'sd1; cc = 16'sd0;
        do_reset();
        send({16'd0, 16'd0, 16'd1}, 1'b1);
        repeat (2) send(48'd0, 1'b1);
        drain("R8");
    endtask

    task automatic t_midreset();
        scen = "R7 mid";
        ca = 16'sd20000; cb = 16'sd5000; cc = -16'sd25000;
        for (int i = 0; i < 4; i++) send({$urandom(), $urandom()}, 1'b1);
        do_reset();
        for (int i = 0; i < 4; i++) send({$urandom(), $urandom()}, 1'b1);
        drain("R7");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in scenario %s", scen);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_samples = '0;
        ca = 16'sd0; cb = 16'sd0; cc = 16'sd0;
        t_reset();
        t_impulse();
        t_random();
        t_gaps();
        t_latency();
        t_trunc();
        t_midreset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule